// File: doc/BRIEF.md
# Synchronous FIFO with Strap-Selected Almost Thresholds

This block is a single-clock first-in, first-out buffer. It stores words of a parameterised width (36 bits by default) in a power-of-two number of entries (1024 by default). Five active-low status outputs report its fill level: empty, full, half-full, almost-empty and almost-full. The almost thresholds come from two offset registers, an empty offset `n` and a full offset `m`. During reset, three strap inputs load both registers with one value taken from a fixed set of eight. After reset, a one-cycle load port can rewrite either register at any time.

Data enters through `wr_en_n`/`wr_data` and leaves through `rd_en_n`/`rd_data`. The flow-control rules work like a valid/ready pair:
- A low `wr_en_n` is a valid write, and `full_n` acts as its ready. A write offered while `full_n` is low is dropped, not held, so the producer must keep the word and offer it again.
- A low `rd_en_n` is a read request, and `empty_n` acts as its ready. A request while `empty_n` is low has no effect.
- An accepted read presents its word on `rd_data` after the next clock edge. `rd_data` then holds that word until the next accepted read.

All five flags are registered. Each one reports the fill level and the offsets as they stand after the most recent clock edge.

Top module: `fifo36_almost`

## Requirements
- R1: While `rst_n` is low at a clock edge, the FIFO empties and, after that edge, shows `empty_n`=0, `full_n`=1, `almost_empty_n`=0, `almost_full_n`=1, `half_full_n`=1 and `rd_data`=0.
- R2: During reset, both offsets load from the code {`strap_ld`,`strap_sel[1]`,`strap_sel[0]`} (default depth 1024). The mapping is: 000→127, 001→255, 010→511, 011→63, 100→31, 101→7, 110→15, 111→3. In general the value is (DEPTH>>k)−1, where k runs 3,2,1,4,5,7,6,8 for codes 0 to 7.
- R3: A write with `wr_en_n`=0 is stored when the FIFO is not full. When it is full, the write is ignored and neither contents nor count change.
- R4: A read request while empty is ignored. It changes neither the count nor `rd_data`.
- R5: Words leave in the order they entered. Each accepted read shows its word on `rd_data` after the next edge, and `rd_data` holds otherwise.
- R6: `empty_n` is a register that is low exactly when the stored count is 0.
- R7: `full_n` is a register that is low exactly when the count equals DEPTH. The first read from a full FIFO raises it after that edge.
- R8: `almost_empty_n` is low exactly when count ≤ `n`.
- R9: `almost_full_n` is low exactly when count ≥ DEPTH − `m`.
- R10: `half_full_n` is low exactly when count > DEPTH/2.
- R11: A read and a write in the same cycle, while neither empty nor full, both take effect and leave the count unchanged.
- R12: With `rst_n` high and `ofs_wr`=1, `ofs_val` (0 to DEPTH−1) is written to `m` when `ofs_sel`=1 and to `n` when `ofs_sel`=0. The flags use the new value from that edge onward.
- R13: The straps are used only while `rst_n` is low. Changing them afterwards alters no threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous master reset, active low |
| strap_ld | input | 1 | Strap, high bit of the default offset code |
| strap_sel | input | 2 | Strap, low bits of the default offset code |
| wr_en_n | input | 1 | Write request, active low |
| wr_data | input | WIDTH | Word to store |
| rd_en_n | input | 1 | Read request, active low |
| rd_data | output | WIDTH | Registered word from the latest accepted read |
| ofs_wr | input | 1 | Offset load strobe |
| ofs_sel | input | 1 | 0 selects empty offset n, 1 selects full offset m |
| ofs_val | input | log2(DEPTH) | Offset value to load |
| empty_n | output | 1 | Empty flag, active low |
| full_n | output | 1 | Full flag, active low |
| almost_empty_n | output | 1 | Almost-empty flag, active low |
| almost_full_n | output | 1 | Almost-full flag, active low |
| half_full_n | output | 1 | Half-full flag, active low |

## Verification
A read and a write can fall in the same cycle. Three cases matter:
- In the middle of the range, both must take effect with no change in count.
- When the FIFO is full, the write must be dropped while the read releases `full_n`.
- When the FIFO is empty, the read must be dropped while the write lowers nothing.

The bench drives combined requests in all three states, and also a threshold load in the same cycle as a data move. It judges each cycle against a queue-based model and also makes targeted checks at each threshold crossing.

// File: rtl/fifo36_pkg.sv
package fifo36_pkg;

  // Right-shift applied to DEPTH for each 3-bit strap code {ld, sel1, sel0}.
  function automatic int unsigned strap_shift(logic [2:0] code);
    int unsigned sh;
    case (code)
      3'b000:  sh = 3;
      3'b001:  sh = 2;
      3'b010:  sh = 1;
      3'b011:  sh = 4;
      3'b100:  sh = 5;
      3'b101:  sh = 7;
      3'b110:  sh = 6;
      default: sh = 8;
    endcase
    return sh;
  endfunction

  // Default almost offset for a code; clamps to zero on shallow builds.
  function automatic int unsigned strap_offset(int unsigned depth, logic [2:0] code);
    int unsigned part;
    part = depth >> strap_shift(code);
    if (part == 0) return 0;
    return part - 1;
  endfunction

  typedef struct packed {
    logic empty_n;
    logic full_n;
    logic aempty_n;
    logic afull_n;
    logic half_n;
  } flag_t;

endpackage

// File: rtl/fifo36_store.sv
module fifo36_store #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 36,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ok,
  input  logic [AW-1:0]    wptr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_ok,
  input  logic [AW-1:0]    rptr,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_ok) rd_data <= mem[rptr];
  end

endmodule

// File: rtl/fifo36_ctrl.sv
module fifo36_ctrl #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_n,
  input  logic          rd_en_n,
  output logic          wr_ok,
  output logic          rd_ok,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_d
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  assign wr_ok = rst_n && !wr_en_n && (cnt_q != FULL_CNT);
  assign rd_ok = rst_n && !rd_en_n && (cnt_q != '0);

  always_comb begin
    if (!rst_n) cnt_d = '0;
    else begin
      case ({wr_ok, rd_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ok) wptr <= wptr + 1'b1;
      if (rd_ok) rptr <= rptr + 1'b1;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/fifo36_offsets.sv
module fifo36_offsets #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_ld,
  input  logic [1:0]    strap_sel,
  input  logic          ofs_wr,
  input  logic          ofs_sel,
  input  logic [AW-1:0] ofs_val,
  output logic [AW-1:0] e_q,
  output logic [AW-1:0] f_q,
  output logic [AW-1:0] e_d,
  output logic [AW-1:0] f_d
);

  logic [AW-1:0] dflt [8];

  for (genvar i = 0; i < 8; i++) begin : g_dflt
    assign dflt[i] = AW'(fifo36_pkg::strap_offset(DEPTH, 3'(i)));
  end

  always_comb begin
    e_d = e_q;
    f_d = f_q;
    if (!rst_n) begin
      e_d = dflt[{strap_ld, strap_sel}];
      f_d = dflt[{strap_ld, strap_sel}];
    end else if (ofs_wr) begin
      if (ofs_sel) f_d = ofs_val;
      else         e_d = ofs_val;
    end
  end

  always_ff @(posedge clk) begin
    e_q <= e_d;
    f_q <= f_d;
  end

endmodule

// File: rtl/fifo36_flags.sv
module fifo36_flags #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic              clk,
  input  logic [CW-1:0]     cnt_d,
  input  logic [AW-1:0]     e_d,
  input  logic [AW-1:0]     f_d,
  output fifo36_pkg::flag_t flags
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  logic [CW-1:0] af_thr;
  fifo36_pkg::flag_t nxt;

  assign af_thr = FULL_CNT - CW'(f_d);

  always_comb begin
    nxt.empty_n  = (cnt_d != '0);
    nxt.full_n   = (cnt_d != FULL_CNT);
    nxt.aempty_n = (cnt_d > CW'(e_d));
    nxt.afull_n  = (cnt_d < af_thr);
    nxt.half_n   = (cnt_d <= HALF_CNT);
  end

  always_ff @(posedge clk) flags <= nxt;

endmodule

// File: rtl/fifo36_almost.sv
module fifo36_almost #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 36,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_ld,
  input  logic [1:0]       strap_sel,
  input  logic             wr_en_n,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en_n,
  output logic [WIDTH-1:0] rd_data,
  input  logic             ofs_wr,
  input  logic             ofs_sel,
  input  logic [AW-1:0]    ofs_val,
  output logic             empty_n,
  output logic             full_n,
  output logic             almost_empty_n,
  output logic             almost_full_n,
  output logic             half_full_n
);

  localparam int CW = AW + 1;

  logic          wr_ok, rd_ok;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] ofs_e_q, ofs_f_q, ofs_e_d, ofs_f_d;
  fifo36_pkg::flag_t flags;

  fifo36_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n),
    .wr_ok(wr_ok), .rd_ok(rd_ok), .wptr(wptr), .rptr(rptr),
    .cnt_q(cnt_q), .cnt_d(cnt_d)
  );

  fifo36_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wptr(wptr), .wr_data(wr_data),
    .rd_ok(rd_ok), .rptr(rptr), .rd_data(rd_data)
  );

  fifo36_offsets #(.DEPTH(DEPTH)) u_ofs (
    .clk(clk), .rst_n(rst_n), .strap_ld(strap_ld), .strap_sel(strap_sel),
    .ofs_wr(ofs_wr), .ofs_sel(ofs_sel), .ofs_val(ofs_val),
    .e_q(ofs_e_q), .f_q(ofs_f_q), .e_d(ofs_e_d), .f_d(ofs_f_d)
  );

  fifo36_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .cnt_d(cnt_d), .e_d(ofs_e_d), .f_d(ofs_f_d), .flags(flags)
  );

  assign empty_n        = flags.empty_n;
  assign full_n         = flags.full_n;
  assign almost_empty_n = flags.aempty_n;
  assign almost_full_n  = flags.afull_n;
  assign half_full_n    = flags.half_n;

endmodule

// File: rtl/fifo36_almost_chk.sv
module fifo36_almost_chk #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 36,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en_n,
  input logic             rd_en_n,
  input logic [CW-1:0]    cnt_q,
  input logic [AW-1:0]    ofs_e_q,
  input logic [AW-1:0]    ofs_f_q,
  input logic [WIDTH-1:0] rd_data,
  input logic             empty_n,
  input logic             full_n,
  input logic             almost_empty_n,
  input logic             almost_full_n,
  input logic             half_full_n
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  assert_empty_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    empty_n == (cnt_q != '0));

  assert_full_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    full_n == (cnt_q != FULL_CNT));

  assert_full_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && !rd_en_n) |=> full_n);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && rd_en_n) |=> (!full_n && $stable(cnt_q)));

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && wr_en_n) |=> (!empty_n && $stable(rd_data)));

  assert_almost_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    almost_empty_n == (cnt_q > CW'(ofs_e_q)));

  assert_almost_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    almost_full_n == (cnt_q < (FULL_CNT - CW'(ofs_f_q))));

  assert_half_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    half_full_n == (cnt_q <= HALF_CNT));

  assert_rw_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_n && !rd_en_n && empty_n && full_n) |=> $stable(cnt_q));

endmodule

bind fifo36_almost fifo36_almost_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n),
  .cnt_q(cnt_q), .ofs_e_q(ofs_e_q), .ofs_f_q(ofs_f_q), .rd_data(rd_data),
  .empty_n(empty_n), .full_n(full_n), .almost_empty_n(almost_empty_n),
  .almost_full_n(almost_full_n), .half_full_n(half_full_n)
);

// File: tb/fifo36_almost_test.sv
`timescale 1ns/1ps
module fifo36_almost_test;

  localparam int D  = 1024;
  localparam int W  = 36;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          strap_ld = 1'b0;
  logic [1:0]    strap_sel = 2'b00;
  logic          wr_en_n = 1'b1;
  logic [W-1:0]  wr_data = '0;
  logic          rd_en_n = 1'b1;
  logic [W-1:0]  rd_data;
  logic          ofs_wr = 1'b0;
  logic          ofs_sel = 1'b0;
  logic [AW-1:0] ofs_val = '0;
  logic          empty_n, full_n, almost_empty_n, almost_full_n, half_full_n;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  fifo36_almost #(.DEPTH(D), .WIDTH(W)) uut (.*);

  // Reference model state
  logic [W-1:0] q[$];
  int           m_n = 0, m_m = 0;
  logic [W-1:0] m_rd = '0;
  bit           started = 0;

  function automatic int exp_ofs(int code);  // R2 table
    case (code)
      0: return 127; 1: return 255; 2: return 511; 3: return 63;
      4: return 31;  5: return 7;   6: return 15;  default: return 3;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_n  = exp_ofs({strap_ld, strap_sel});
      m_m  = m_n;
      m_rd = '0;
      started = 1;
    end else begin
      bit wa, ra;
      wa = !wr_en_n && q.size() < D;
      ra = !rd_en_n && q.size() > 0;
      if (ra) m_rd = q.pop_front();
      if (wa) q.push_back(wr_data);
      if (ofs_wr) begin
        if (ofs_sel) m_m = ofs_val; else m_n = ofs_val;
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      int c;
      c = q.size();
      chk(rd_data == m_rd, "R5 rd_data", rd_data, m_rd);
      chk(empty_n == (c != 0), "R6 empty_n", empty_n, c != 0);
      chk(full_n == (c != D), "R7 full_n", full_n, c != D);
      chk(almost_empty_n == !(c <= m_n), "R8 almost_empty_n", almost_empty_n, !(c <= m_n));
      chk(almost_full_n == !(c >= D - m_m), "R9 almost_full_n", almost_full_n, !(c >= D - m_m));
      chk(half_full_n == !(c > D/2), "R10 half_full_n", half_full_n, !(c > D/2));
    end
  end

  // One cycle of stimulus: called at a falling edge, returns at the next one.
  task automatic step(bit w, bit r, logic [W-1:0] d);
    wr_en_n = !w; rd_en_n = !r; wr_data = d;
    @(negedge clk);
    wr_en_n = 1'b1; rd_en_n = 1'b1;
  endtask

  task automatic do_reset(int code);
    @(negedge clk);
    rst_n = 1'b0;
    {strap_ld, strap_sel} = 3'(code);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic load(bit sel, int val);
    ofs_wr = 1'b1; ofs_sel = sel; ofs_val = AW'(val);
    step(0, 0, '0);
    ofs_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int k;
    logic [W-1:0] held;
    // R1: reset state
    do_reset(0);
    chk(empty_n == 0 && full_n == 1 && almost_empty_n == 0 && almost_full_n == 1 &&
        half_full_n == 1 && rd_data == 0, "R1 reset flags",
        {empty_n, full_n, almost_empty_n, almost_full_n, half_full_n}, 5'b01011);

    // R2: each strap code sets n; almost_empty_n rises at count n+1
    for (int code = 0; code < 8; code++) begin
      do_reset(code);
      k = 0;
      while (almost_empty_n == 0 && k < D) begin
        step(1, 0, W'(k));
        k++;
      end
      chk(k == exp_ofs(code) + 1, "R2 strap default", k, exp_ofs(code) + 1);
    end

    // R13: straps changed after reset have no effect
    do_reset(0);
    {strap_ld, strap_sel} = 3'b111;
    k = 0;
    while (almost_empty_n == 0 && k < D) begin
      step(1, 0, W'(k + 5));
      k++;
    end
    chk(k == 128, "R13 straps ignored after reset", k, 128);

    // R12: load thresholds n=5, m=10 (load shares a cycle with a write)
    do_reset(2);
    ofs_wr = 1'b1; ofs_sel = 1'b0; ofs_val = 10'd5;
    step(1, 0, 36'h1);
    ofs_wr = 1'b0;
    load(1, 10);
    for (int i = 0; i < 4; i++) step(1, 0, W'(36'hA00 + i));
    chk(almost_empty_n == 0, "R12 n=5 at count 5", almost_empty_n, 0);
    step(1, 0, 36'hABC);
    chk(almost_empty_n == 1, "R12 n=5 at count 6", almost_empty_n, 1);

    // R11: simultaneous read and write in the middle
    step(1, 1, 36'h5A5A5);
    step(1, 1, 36'h12345);

    // fill to one below the almost-full threshold (1014)
    while (q.size() < D - 11) step(1, 0, W'(q.size() * 7));
    chk(almost_full_n == 1, "R9 count 1013", almost_full_n, 1);
    step(1, 0, 36'hF00D);
    chk(almost_full_n == 0, "R9 count 1014", almost_full_n, 0);
    while (q.size() < D) step(1, 0, W'(q.size() + 36'h100000));
    chk(full_n == 0, "R7 full at DEPTH", full_n, 0);

    // R3: write while full is ignored
    step(1, 0, 36'hDEAD);
    chk(full_n == 0 && q.size() == D, "R3 write ignored when full", full_n, 0);

    // R7: read and write together while full: write dropped, full released
    step(1, 1, 36'hBEEF);
    chk(full_n == 1, "R7 first read releases full", full_n, 1);

    // drain, with a combined request every 50 words
    k = 0;
    while (q.size() > 0) begin
      step(k % 50 == 0, 1, W'(k));
      k++;
    end
    chk(empty_n == 0, "R6 empty after last read", empty_n, 0);

    // R4: reads while empty are ignored
    held = rd_data;
    step(0, 1, '0);
    step(0, 1, '0);
    chk(rd_data == held && empty_n == 0, "R4 read ignored when empty", rd_data, held);

    // read and write together while empty: only the write lands
    step(1, 1, 36'h777);
    chk(empty_n == 1 && rd_data == held, "R4 combined on empty", rd_data, held);
    step(0, 1, '0);
    chk(rd_data == 36'h777, "R5 word read back", rd_data, 36'h777);

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule